// File: doc/BRIEF.md
# Reconfigurable Five-Way Majority Voter

This block takes one result word from each of five redundant processing modules in the same clock cycle and emits a single voted word. The voted word is the value held by more than half of the modules that are still enabled. Any enabled module that disagrees with the voted word gets a sticky fault flag and one more strike on its own saturating counter. When that counter reaches a programmable threshold, the module is dropped from all later votes. The block then runs at a lower redundancy level, and the modules that remain can still mask faults among themselves.

When the enabled modules have no strict majority, the block raises an alarm instead of producing a result. This covers two survivors that disagree, an even split and an empty mask. In that case the output holds its last good value. A fail-safe mode tightens the rule: the value passes only when every enabled module agrees, and any mismatch drives a programmed safe word instead. Software can rewrite the enable mask to bring repaired modules back, and clears fault flags by writing ones. The modules are assumed to run in lockstep.

Top module: `nmr_voter`

## Requirements
- R1: A result is registered one clock after `in_valid_i` is sampled high; `vote_valid_o`, `agree_o` and `alarm_o` are single-cycle pulses for that input and stay low in a cycle that follows no accepted input.
- R2: In normal mode the voted word is the value shared by more than half of the enabled modules (module i supplies bits [8i+7:8i] of `mod_data_i`); the data of a disabled module has no effect on the vote.
- R3: `agree_o` is high only when every enabled module supplied the voted word; it is never high without `vote_valid_o`.
- R4: An enabled module whose word differs from the majority word sets its fault flag (bit i for module i), which stays set until `flag_clr_i` bit i is written one; a new disagreement in the same cycle as a clear leaves the flag set.
- R5: Each module has a 3-bit strike counter that saturates at 7 and adds one on every disagreement; when the count after a strike is at least a nonzero `threshold_i`, the module's enable bit clears at that same edge; a threshold of zero never drops a module.
- R6: When the enabled modules have no strict majority (two that differ, an even split, or none enabled) in normal mode, `alarm_o` pulses, `vote_valid_o` stays low, `vote_o` keeps its previous value, and no flag or counter changes.
- R7: With `fail_safe_i` high, the voted word passes only when all enabled modules agree; otherwise `vote_o` is `safe_value_i` with `vote_valid_o` high and `agree_o` low. Flags and strikes follow R4 and R5 when a majority exists, and `alarm_o` also pulses when none exists.
- R8: `mask_wr_i` loads the enable mask from `mask_wdata_i` at the next edge and overrides any drop in that cycle. The vote in that cycle still uses the old mask. Every module written one has its strike counter cleared.
- R9: After reset all five modules are enabled, all flags are zero, `vote_o` is zero and the three pulse outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | Module words are present this cycle |
| mod_data_i | input | 40 | Five packed result words, module 0 in the low byte |
| fail_safe_i | input | 1 | Require unanimous agreement |
| safe_value_i | input | 8 | Word driven on a fail-safe mismatch |
| threshold_i | input | 3 | Strikes that drop a module; zero disables dropping |
| mask_wr_i | input | 1 | Load the enable mask |
| mask_wdata_i | input | 5 | New enable mask |
| flag_clr_i | input | 5 | Write-one-to-clear for fault flags |
| vote_o | output | 8 | Voted word |
| vote_valid_o | output | 1 | Voted word produced for the last input |
| agree_o | output | 1 | All enabled modules agreed |
| alarm_o | output | 1 | No majority among enabled modules |
| fault_flags_o | output | 5 | Sticky per-module disagreement flags |
| enabled_o | output | 5 | Modules currently taking part in the vote |

## Verification
The bench aims at the edges of the degradation path. It checks a drop on exactly the threshold-th strike; a design that compares with the wrong bound would drop one vote early or late. It checks that a dropped module's stray word no longer spoils agreement, and it ends with two disagreeing survivors that must hold the old word rather than pick one. It also counts strikes past the counter's top and then lowers the threshold to seven, so a counter that wraps would fail to drop the module. Other cases cover an even split, an empty mask, a clear landing in the same cycle as a new fault, and a mask write landing in the same cycle as a vote, which would expose a design that applies the new mask too early.

// File: rtl/nmr_pkg.sv
package nmr_pkg;

    // Outcome of one vote attempt
    typedef enum logic [1:0] {
        OC_IDLE  = 2'd0,   // no input this cycle
        OC_PASS  = 2'd1,   // majority word goes out
        OC_SAFE  = 2'd2,   // fail-safe mismatch, safe word goes out
        OC_NOMAJ = 2'd3    // no strict majority among enabled modules
    } outcome_e;

endpackage

// File: rtl/nmr_agree_matrix.sv
module nmr_agree_matrix #(
    parameter int N = 5,
    parameter int W = 8
) (
    input  logic [N*W-1:0] data_i,
    input  logic [N-1:0]   en_i,
    output logic [W-1:0]   maj_word_o,
    output logic           has_maj_o,
    output logic           all_agree_o,
    output logic [N-1:0]   match_o
);
    localparam int CW = $clog2(N + 1) + 1;

    logic [CW-1:0] n_act;
    logic [CW-1:0] peers [N];

    always_comb begin
        n_act = '0;
        for (int i = 0; i < N; i++) begin
            if (en_i[i]) n_act = n_act + 1'b1;
        end
        for (int i = 0; i < N; i++) begin
            peers[i] = '0;
            for (int j = 0; j < N; j++) begin
                if (en_i[j] && (data_i[j*W +: W] == data_i[i*W +: W])) begin
                    peers[i] = peers[i] + 1'b1;
                end
            end
        end
        has_maj_o  = 1'b0;
        maj_word_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (en_i[i] && ((peers[i] << 1) > n_act)) begin
                has_maj_o  = 1'b1;
                maj_word_o = data_i[i*W +: W];
            end
        end
        for (int i = 0; i < N; i++) begin
            match_o[i] = has_maj_o && en_i[i] && (data_i[i*W +: W] == maj_word_o);
        end
        all_agree_o = has_maj_o && (match_o == en_i);
    end

endmodule

// File: rtl/nmr_strike_ctr.sv
module nmr_strike_ctr #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strike_i,
    input  logic             clear_i,
    input  logic [CNT_W-1:0] thr_i,
    output logic             reach_o
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    logic [CNT_W-1:0] count_d, count_q, bumped;

    always_comb begin
        bumped  = (count_q == TOP) ? count_q : count_q + 1'b1;
        reach_o = strike_i && (thr_i != '0) && (bumped >= thr_i);
        count_d = count_q;
        if (clear_i)       count_d = '0;
        else if (strike_i) count_d = bumped;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    // R5: counter holds at its top value
    a_r5_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (strike_i && !clear_i && count_q == TOP) |=> (count_q == TOP));

    // R5: one strike adds exactly one below the top
    a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
        (strike_i && !clear_i && count_q != TOP) |=> (count_q == $past(count_q) + 1'b1));

endmodule

// File: rtl/nmr_voter.sv
module nmr_voter #(
    parameter int N_MOD = 5,
    parameter int W     = 8,
    parameter int CNT_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid_i,
    input  logic [N_MOD*W-1:0] mod_data_i,
    input  logic               fail_safe_i,
    input  logic [W-1:0]       safe_value_i,
    input  logic [CNT_W-1:0]   threshold_i,
    input  logic               mask_wr_i,
    input  logic [N_MOD-1:0]   mask_wdata_i,
    input  logic [N_MOD-1:0]   flag_clr_i,
    output logic [W-1:0]       vote_o,
    output logic               vote_valid_o,
    output logic               agree_o,
    output logic               alarm_o,
    output logic [N_MOD-1:0]   fault_flags_o,
    output logic [N_MOD-1:0]   enabled_o
);
    import nmr_pkg::*;

    typedef struct packed {
        logic [N_MOD-1:0] en;
        logic [N_MOD-1:0] flag;
        logic [W-1:0]     vote;
        logic             valid;
        logic             agree;
        logic             alarm;
    } st_t;

    st_t st_d, st_q;

    logic [W-1:0]     maj_word;
    logic             has_maj, all_agree;
    logic [N_MOD-1:0] match, strike, reach, ctr_clr;
    outcome_e         oc;

    nmr_agree_matrix #(.N(N_MOD), .W(W)) u_matrix (
        .data_i      (mod_data_i),
        .en_i        (st_q.en),
        .maj_word_o  (maj_word),
        .has_maj_o   (has_maj),
        .all_agree_o (all_agree),
        .match_o     (match)
    );

    // Decide outcome and which modules take a strike
    always_comb begin
        oc     = OC_IDLE;
        strike = '0;
        if (in_valid_i) begin
            if (!has_maj) begin
                oc = OC_NOMAJ;
            end else begin
                strike = st_q.en & ~match;
                oc     = (fail_safe_i && !all_agree) ? OC_SAFE : OC_PASS;
            end
        end
        ctr_clr = mask_wr_i ? mask_wdata_i : '0;
    end

    for (genvar g = 0; g < N_MOD; g++) begin : g_ctr
        nmr_strike_ctr #(.CNT_W(CNT_W)) u_ctr (
            .clk      (clk),
            .rst_n    (rst_n),
            .strike_i (strike[g]),
            .clear_i  (ctr_clr[g]),
            .thr_i    (threshold_i),
            .reach_o  (reach[g])
        );
    end

    // Next state
    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.agree = 1'b0;
        st_d.alarm = 1'b0;
        case (oc)
            OC_PASS: begin
                st_d.vote  = maj_word;
                st_d.valid = 1'b1;
                st_d.agree = all_agree;
            end
            OC_SAFE: begin
                st_d.vote  = safe_value_i;
                st_d.valid = 1'b1;
            end
            OC_NOMAJ: begin
                st_d.alarm = 1'b1;
                if (fail_safe_i) begin
                    st_d.vote  = safe_value_i;
                    st_d.valid = 1'b1;
                end
            end
            default: ;
        endcase
        st_d.flag = (st_q.flag & ~flag_clr_i) | strike;
        st_d.en   = mask_wr_i ? mask_wdata_i : (st_q.en & ~reach);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.en    <= '1;
        end else begin
            st_q       <= st_d;
        end
    end

    assign vote_o        = st_q.vote;
    assign vote_valid_o  = st_q.valid;
    assign agree_o       = st_q.agree;
    assign alarm_o       = st_q.alarm;
    assign fault_flags_o = st_q.flag;
    assign enabled_o     = st_q.en;

    // R1: a result only follows an accepted input
    a_r1_valid_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
        vote_valid_o |-> $past(in_valid_i));

    // R3: agreement is never reported without a result
    a_r3_agree_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
        agree_o |-> vote_valid_o);

    // R6: no majority in normal mode holds the output and raises the alarm
    a_r6_hold_on_nomaj: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && !fail_safe_i && !has_maj) |=> (alarm_o && !vote_valid_o && $stable(vote_o)));

    // R7: fail-safe mismatch emits the safe word
    a_r7_safe_word: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && fail_safe_i && !all_agree)
            |=> (vote_valid_o && !agree_o && vote_o == $past(safe_value_i)));

    // R4: flags only fall through an explicit clear
    a_r4_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_i == '0) |=> ((~fault_flags_o & $past(fault_flags_o)) == '0));

    // R5: a dropped module only returns through a mask write
    a_r5_no_revive: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_wr_i |=> ((enabled_o & ~$past(enabled_o)) == '0));

endmodule

// File: tb/sim_nmr_voter.sv
module sim_nmr_voter;
    localparam logic [7:0] SAFE = 8'h5A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid_i = 1'b0;
    logic [39:0] mod_data_i = '0;
    logic        fail_safe_i = 1'b0;
    logic [7:0]  safe_value_i = SAFE;
    logic [2:0]  threshold_i = 3'd2;
    logic        mask_wr_i = 1'b0;
    logic [4:0]  mask_wdata_i = '0;
    logic [4:0]  flag_clr_i = '0;
    logic [7:0]  vote_o;
    logic        vote_valid_o, agree_o, alarm_o;
    logic [4:0]  fault_flags_o, enabled_o;

    always #10 clk = ~clk;

    nmr_voter u0 (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .mod_data_i(mod_data_i),
        .fail_safe_i(fail_safe_i), .safe_value_i(safe_value_i), .threshold_i(threshold_i),
        .mask_wr_i(mask_wr_i), .mask_wdata_i(mask_wdata_i), .flag_clr_i(flag_clr_i),
        .vote_o(vote_o), .vote_valid_o(vote_valid_o), .agree_o(agree_o), .alarm_o(alarm_o),
        .fault_flags_o(fault_flags_o), .enabled_o(enabled_o)
    );

    typedef struct {
        logic [7:0] vote;
        logic       valid, agree, alarm;
        logic [4:0] flags, en;
        string      req;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;

    // reference state
    logic [4:0] m_en = 5'b11111;
    logic [4:0] m_flags = '0;
    logic [7:0] m_vote = '0;
    int         m_cnt [5] = '{0, 0, 0, 0, 0};

    function automatic logic [39:0] pk(logic [7:0] a, logic [7:0] b, logic [7:0] c,
                                       logic [7:0] d, logic [7:0] e);
        return {e, d, c, b, a};
    endfunction

    task automatic step(input bit iv, input logic [39:0] d, input bit fs, input logic [2:0] thr,
                        input bit mwr, input logic [4:0] mwd, input logic [4:0] clr,
                        input string req);
        exp_t       e;
        int         nact, c;
        bit         hasm, allag;
        logic [7:0] mv;
        logic [4:0] strike;
        @(negedge clk);
        in_valid_i = iv; mod_data_i = d; fail_safe_i = fs; threshold_i = thr;
        mask_wr_i = mwr; mask_wdata_i = mwd; flag_clr_i = clr;
        nact = 0;
        for (int i = 0; i < 5; i++) if (m_en[i]) nact++;
        hasm = 1'b0; mv = '0;
        for (int i = 0; i < 5; i++) begin
            if (m_en[i]) begin
                c = 0;
                for (int j = 0; j < 5; j++) if (m_en[j] && d[j*8 +: 8] == d[i*8 +: 8]) c++;
                if (2 * c > nact) begin hasm = 1'b1; mv = d[i*8 +: 8]; end
            end
        end
        allag = hasm;
        for (int i = 0; i < 5; i++) if (m_en[i] && d[i*8 +: 8] != mv) allag = 1'b0;
        e.valid = 1'b0; e.agree = 1'b0; e.alarm = 1'b0; strike = '0;
        if (iv) begin
            if (!hasm) begin
                e.alarm = 1'b1;
                if (fs) begin m_vote = SAFE; e.valid = 1'b1; end
            end else begin
                e.valid = 1'b1;
                e.agree = allag;
                m_vote  = (fs && !allag) ? SAFE : mv;
                for (int i = 0; i < 5; i++) if (m_en[i] && d[i*8 +: 8] != mv) strike[i] = 1'b1;
            end
        end
        m_flags = (m_flags & ~clr) | strike;
        for (int i = 0; i < 5; i++) begin
            if (strike[i]) begin
                if (m_cnt[i] < 7) m_cnt[i]++;
                if (thr != 0 && m_cnt[i] >= int'(thr)) m_en[i] = 1'b0;
            end
        end
        if (mwr) begin
            m_en = mwd;
            for (int i = 0; i < 5; i++) if (mwd[i]) m_cnt[i] = 0;
        end
        e.vote = m_vote; e.flags = m_flags; e.en = m_en; e.req = req;
        @(posedge clk);
        #1 q.push_back(e);
    endtask

    // monitor: compare registered outputs away from the edge
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                e = q.pop_front();
                checks++;
                if (vote_o !== e.vote || vote_valid_o !== e.valid || agree_o !== e.agree ||
                    alarm_o !== e.alarm || fault_flags_o !== e.flags || enabled_o !== e.en) begin
                    failures++;
                    $display("FAIL %s: got vote=%h v=%b ag=%b al=%b fl=%b en=%b, expected vote=%h v=%b ag=%b al=%b fl=%b en=%b",
                             e.req, vote_o, vote_valid_o, agree_o, alarm_o, fault_flags_o, enabled_o,
                             e.vote, e.valid, e.agree, e.alarm, e.flags, e.en);
                end
            end
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;   // R9 reset state
        if (enabled_o !== 5'b11111 || fault_flags_o !== 5'b0 || vote_o !== 8'h00 ||
            vote_valid_o !== 1'b0 || agree_o !== 1'b0 || alarm_o !== 1'b0) begin
            failures++;
            $display("FAIL R9: got en=%b fl=%b vote=%h v=%b ag=%b al=%b, expected en=11111 fl=00000 vote=00 v=0 ag=0 al=0",
                     enabled_o, fault_flags_o, vote_o, vote_valid_o, agree_o, alarm_o);
        end
        rst_n = 1'b1;
        step(1, pk(8'h11, 8'h11, 8'h11, 8'h11, 8'h11), 0, 2, 0, 0, 0, "R2 unanimous");
        step(1, pk(8'h22, 8'h22, 8'h22, 8'h22, 8'h99), 0, 2, 0, 0, 0, "R4 single fault flagged");
        step(1, pk(8'h33, 8'h33, 8'h33, 8'h44, 8'h55), 0, 2, 0, 0, 0, "R5 two faults masked, drop at threshold");
        step(1, pk(8'h66, 8'h66, 8'h66, 8'h66, 8'h77), 0, 2, 0, 0, 0, "R2 R3 dropped module ignored");
        step(1, pk(8'h88, 8'h88, 8'h88, 8'h44, 8'h88), 0, 2, 0, 0, 5'b11000, "R4 set beats clear");
        step(1, pk(8'hAA, 8'hAA, 8'hBB, 8'hFF, 8'hFF), 0, 2, 0, 0, 0, "R4 three-way vote");
        step(1, pk(8'hAA, 8'hAA, 8'hBB, 8'hFF, 8'hFF), 0, 2, 0, 0, 0, "R5 drop to two");
        step(1, pk(8'hC1, 8'hC2, 8'hAA, 8'hAA, 8'hAA), 0, 2, 0, 0, 0, "R6 two survivors differ");
        step(0, pk(8'hD0, 8'hD0, 8'h00, 8'h00, 8'h00), 0, 2, 0, 0, 0, "R1 no input no result");
        step(1, pk(8'hD0, 8'hD0, 8'h01, 8'h02, 8'h03), 0, 2, 0, 0, 0, "R3 two survivors agree");
        step(1, pk(8'hE0, 8'hE0, 8'h01, 8'h02, 8'h03), 0, 2, 1, 5'b11111, 0, "R8 write uses old mask");
        for (int k = 0; k < 3; k++)
            step(1, pk(8'h12, 8'h12, 8'h12, 8'h12, 8'h34), 0, 0, 0, 0, 0, "R5 threshold zero keeps module");
        step(0, '0, 0, 0, 1, 5'b01111, 5'b11111, "R8 mask to four");
        step(1, pk(8'h21, 8'h21, 8'h31, 8'h31, 8'h21), 0, 0, 0, 0, 0, "R6 even split");
        step(0, '0, 1, 0, 1, 5'b11111, 0, "R8 restore all");
        step(1, pk(8'h42, 8'h42, 8'h42, 8'h42, 8'h42), 1, 0, 0, 0, 0, "R7 unanimous passes");
        step(1, pk(8'h42, 8'h43, 8'h42, 8'h42, 8'h42), 1, 0, 0, 0, 0, "R7 mismatch gives safe word");
        step(1, pk(8'h01, 8'h02, 8'h03, 8'h04, 8'h05), 1, 0, 0, 0, 0, "R7 no majority safe and alarm");
        step(0, '0, 0, 0, 1, 5'b00000, 5'b11111, "R8 empty mask");
        step(1, pk(8'h77, 8'h77, 8'h77, 8'h77, 8'h77), 0, 0, 0, 0, 0, "R6 nothing enabled");
        step(0, '0, 0, 0, 1, 5'b11111, 0, "R8 counters cleared");
        for (int k = 0; k < 9; k++)
            step(1, pk(8'h0F, 8'h3C, 8'h3C, 8'h3C, 8'h3C), 0, 0, 0, 0, 0, "R5 strikes past top");
        step(1, pk(8'h0F, 8'h3C, 8'h3C, 8'h3C, 8'h3C), 0, 7, 0, 0, 0, "R5 saturated count drops at seven");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule